// File: doc/BRIEF.md
# Receive Queue Index Manager

This block keeps the write and read positions of a circular receive queue whose elements live in a shared message memory. The memory is outside the block. When an upstream filter accepts a frame, it raises a store request. The block then says whether the frame may be written, and where. It does this by giving a write strobe and the slot address, formed from a programmable section base plus the write position times a fixed element size. The application reads the element at the read address, then pulses an acknowledge to release it.

The queue depth is set at start-up to any value from 1 to the compiled maximum. Two policies govern a store request that finds the queue full:

- **Blocking:** the frame is discarded and a sticky lost-frame flag is raised.
- **Overwrite:** the frame replaces the oldest element, and the read position moves on with the write position.

Each position carries a wrap bit. The wrap bits let the block tell a full queue from an empty one and derive the fill level without a separate counter.

Top module: `rxq_index_mgr`

## Requirements
- R1: A synchronous active-high reset clears both positions, both wrap bits and the lost flag. After reset the queue reads empty, not full, with a fill level of 0.
- R2: Each store that is taken raises `wr_en` in the same cycle and advances `put_idx` by one at the next clock edge. After slot depth-1 it returns to slot 0. Without a taken store, `put_idx` holds.
- R3: `get_idx` advances by one only on an acknowledge while the queue is not empty, or on an overwrite. After slot depth-1 it returns to 0. An acknowledge to an empty queue leaves `get_idx`, the fill level and `empty` unchanged.
- R4: `wr_addr` = `cfg_base` + `put_idx` × ELEM_WORDS, and `rd_addr` = `cfg_base` + `get_idx` × ELEM_WORDS, both modulo 2^ADDR_W.
- R5: `fill_level` = number of stored unread elements = (put − get) modulo depth, using the wrap bits to separate the cases. `full` is high exactly when the fill level equals the depth. `empty` is high exactly when it is 0.
- R6: In blocking mode (`cfg_overwrite` = 0), a store to a full queue with no acknowledge in that cycle keeps `wr_en` low, leaves both positions unchanged and sets `lost_flag`.
- R7: `lost_flag` stays set until a cycle with `lost_clr` high. If a new drop happens in the same cycle as `lost_clr`, the flag stays set.
- R8: In overwrite mode (`cfg_overwrite` = 1), a store to a full queue with no acknowledge raises `wr_en`, with `wr_addr` equal to `rd_addr` (the oldest slot). Both positions then advance, the fill level stays at the depth, and `lost_flag` is not set.
- R9: A store and an acknowledge in the same cycle on a non-empty queue advance both positions, and the fill level is unchanged. This also holds for a full queue in either mode: the acknowledge frees room, so the frame is taken and nothing is lost.
- R10: A `cfg_depth` of 0 acts as depth 1. A `cfg_depth` above MAX_DEPTH acts as MAX_DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_depth | input | CNT_W | Queue depth in elements, static during operation |
| cfg_overwrite | input | 1 | Full-queue policy: 0 = blocking, 1 = overwrite |
| cfg_base | input | ADDR_W | Section start address in the message memory |
| frame_store | input | 1 | Store request for an accepted frame |
| elem_ack | input | 1 | Application has read the element at `rd_addr` |
| lost_clr | input | 1 | Write-one-to-clear for `lost_flag` |
| wr_en | output | 1 | The frame is written to `wr_addr` this cycle |
| wr_addr | output | ADDR_W | Slot address for the next stored frame |
| rd_addr | output | ADDR_W | Slot address of the oldest unread element |
| put_idx | output | IDX_W | Write position |
| get_idx | output | IDX_W | Read position |
| fill_level | output | CNT_W | Number of unread elements |
| full | output | 1 | Fill level equals depth |
| empty | output | 1 | Fill level is zero |
| lost_flag | output | 1 | Sticky: a frame was dropped in blocking mode |

## Verification
The bench uses the default parameters: MAX_DEPTH = 64, ELEM_WORDS = 18 and ADDR_W = 16. It runs the block at configured depths of 1, 5, 7 and 64, and applies the out-of-range settings 0 and 100.

- Depth 1 makes every store toggle the wrap bits, so each store moves the queue straight between empty and full.
- Depth 5 and depth 7 exercise wrap-around at a non-power-of-two limit.
- Depth 64 at a section base of 0xFF00 pushes the slot address past 2^16, which brings address wrap into reach.

Directed sequences cover drops, the sticky flag, overwrite, and simultaneous store and acknowledge at full. Biased random phases alternate between mostly filling and mostly draining.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic {
        RXQ_MODE_BLOCK     = 1'b0,
        RXQ_MODE_OVERWRITE = 1'b1
    } rxq_mode_e;

    typedef enum logic [1:0] {
        RXQ_EV_IDLE      = 2'd0,
        RXQ_EV_STORE     = 2'd1,
        RXQ_EV_DROP      = 2'd2,
        RXQ_EV_OVERWRITE = 2'd3
    } rxq_event_e;

endpackage

// File: rtl/rxq_depth_sel.sv
module rxq_depth_sel #(
    parameter int MAX_DEPTH = 64,
    parameter int CNT_W     = 7,
    parameter int IDX_W     = 6
) (
    input  logic [CNT_W-1:0] cfg_depth,
    output logic [CNT_W-1:0] depth,
    output logic [IDX_W-1:0] last_idx
);
    localparam logic [CNT_W-1:0] DEPTH_CAP = CNT_W'(MAX_DEPTH);

    logic [CNT_W-1:0] depth_minus_one;

    always_comb begin
        if (cfg_depth == '0) begin
            depth = CNT_W'(1);
        end else if (cfg_depth > DEPTH_CAP) begin
            depth = DEPTH_CAP;
        end else begin
            depth = cfg_depth;
        end
        depth_minus_one = depth - CNT_W'(1);
        last_idx        = IDX_W'(depth_minus_one);
    end
endmodule

// File: rtl/rxq_ptr_step.sv
module rxq_ptr_step #(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             wrap,
    input  logic             adv,
    input  logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] idx_next,
    output logic             wrap_next
);
    always_comb begin
        idx_next  = idx;
        wrap_next = wrap;
        if (adv) begin
            if (idx == last_idx) begin
                idx_next  = '0;
                wrap_next = ~wrap;
            end else begin
                idx_next = idx + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
    parameter int IDX_W = 6,
    parameter int CNT_W = 7
) (
    input  logic [IDX_W-1:0] put_idx,
    input  logic             put_wrap,
    input  logic [IDX_W-1:0] get_idx,
    input  logic             get_wrap,
    input  logic [CNT_W-1:0] depth,
    output logic [CNT_W-1:0] fill,
    output logic             is_full,
    output logic             is_empty
);
    logic [CNT_W-1:0] put_ext;
    logic [CNT_W-1:0] get_ext;
    logic             same_lap;
    logic             same_slot;

    always_comb begin
        put_ext   = CNT_W'(put_idx);
        get_ext   = CNT_W'(get_idx);
        same_lap  = (put_wrap == get_wrap);
        same_slot = (put_idx == get_idx);
        if (same_lap) begin
            fill = put_ext - get_ext;
        end else begin
            fill = depth - get_ext + put_ext;
        end
        is_full  = same_slot && !same_lap;
        is_empty = same_slot && same_lap;
    end
endmodule

// File: rtl/rxq_addr_gen.sv
module rxq_addr_gen #(
    parameter int ADDR_W     = 16,
    parameter int IDX_W      = 6,
    parameter int ELEM_WORDS = 18
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(ELEM_WORDS);

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = ADDR_W'(idx) * STRIDE;
        addr   = base + offset;
    end
endmodule

// File: rtl/rxq_index_mgr.sv
module rxq_index_mgr
    import rxq_pkg::*;
#(
    parameter int MAX_DEPTH  = 64,
    parameter int ADDR_W     = 16,
    parameter int ELEM_WORDS = 18,
    parameter int IDX_W      = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1,
    parameter int CNT_W      = $clog2(MAX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cfg_depth,
    input  logic              cfg_overwrite,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              frame_store,
    input  logic              elem_ack,
    input  logic              lost_clr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [IDX_W-1:0]  put_idx,
    output logic [IDX_W-1:0]  get_idx,
    output logic [CNT_W-1:0]  fill_level,
    output logic              full,
    output logic              empty,
    output logic              lost_flag
);
    localparam int NUM_PORTS = 2;

    typedef struct packed {
        logic [IDX_W-1:0] put_idx;
        logic             put_wrap;
        logic [IDX_W-1:0] get_idx;
        logic             get_wrap;
        logic             lost;
    } rxq_state_t;

    rxq_state_t state_d;
    rxq_state_t state_q;

    logic [CNT_W-1:0] depth_eff;
    logic [IDX_W-1:0] last_idx;
    logic [CNT_W-1:0] fill_cur;
    logic             full_cur;
    logic             empty_cur;

    rxq_mode_e  mode;
    rxq_event_e evt;
    logic       ack_taken;
    logic       has_room;
    logic       adv_put;
    logic       adv_get;

    logic [IDX_W-1:0] put_idx_nx;
    logic             put_wrap_nx;
    logic [IDX_W-1:0] get_idx_nx;
    logic             get_wrap_nx;

    logic [IDX_W-1:0]  port_idx  [NUM_PORTS];
    logic [ADDR_W-1:0] port_addr [NUM_PORTS];

    rxq_depth_sel #(
        .MAX_DEPTH (MAX_DEPTH),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W)
    ) u_depth_sel (
        .cfg_depth (cfg_depth),
        .depth     (depth_eff),
        .last_idx  (last_idx)
    );

    rxq_level #(
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_level (
        .put_idx  (state_q.put_idx),
        .put_wrap (state_q.put_wrap),
        .get_idx  (state_q.get_idx),
        .get_wrap (state_q.get_wrap),
        .depth    (depth_eff),
        .fill     (fill_cur),
        .is_full  (full_cur),
        .is_empty (empty_cur)
    );

    // Event decode: an acknowledge in the same cycle frees a slot first.
    always_comb begin
        mode      = rxq_mode_e'(cfg_overwrite);
        ack_taken = elem_ack && !empty_cur;
        has_room  = !full_cur || ack_taken;
        if (!frame_store) begin
            evt = RXQ_EV_IDLE;
        end else if (has_room) begin
            evt = RXQ_EV_STORE;
        end else if (mode == RXQ_MODE_OVERWRITE) begin
            evt = RXQ_EV_OVERWRITE;
        end else begin
            evt = RXQ_EV_DROP;
        end
        adv_put = (evt == RXQ_EV_STORE) || (evt == RXQ_EV_OVERWRITE);
        adv_get = ack_taken || (evt == RXQ_EV_OVERWRITE);
    end

    rxq_ptr_step #(
        .IDX_W (IDX_W)
    ) u_put_step (
        .idx       (state_q.put_idx),
        .wrap      (state_q.put_wrap),
        .adv       (adv_put),
        .last_idx  (last_idx),
        .idx_next  (put_idx_nx),
        .wrap_next (put_wrap_nx)
    );

    rxq_ptr_step #(
        .IDX_W (IDX_W)
    ) u_get_step (
        .idx       (state_q.get_idx),
        .wrap      (state_q.get_wrap),
        .adv       (adv_get),
        .last_idx  (last_idx),
        .idx_next  (get_idx_nx),
        .wrap_next (get_wrap_nx)
    );

    always_comb begin
        state_d          = state_q;
        state_d.put_idx  = put_idx_nx;
        state_d.put_wrap = put_wrap_nx;
        state_d.get_idx  = get_idx_nx;
        state_d.get_wrap = get_wrap_nx;
        if (evt == RXQ_EV_DROP) begin
            state_d.lost = 1'b1;
        end else if (lost_clr) begin
            state_d.lost = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign port_idx[0] = state_q.put_idx;
    assign port_idx[1] = state_q.get_idx;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_addr
        rxq_addr_gen #(
            .ADDR_W     (ADDR_W),
            .IDX_W      (IDX_W),
            .ELEM_WORDS (ELEM_WORDS)
        ) u_addr_gen (
            .base (cfg_base),
            .idx  (port_idx[p]),
            .addr (port_addr[p])
        );
    end

    assign wr_en      = adv_put;
    assign wr_addr    = port_addr[0];
    assign rd_addr    = port_addr[1];
    assign put_idx    = state_q.put_idx;
    assign get_idx    = state_q.get_idx;
    assign fill_level = fill_cur;
    assign full       = full_cur;
    assign empty      = empty_cur;
    assign lost_flag  = state_q.lost;
endmodule

// File: rtl/rxq_index_mgr_chk.sv
module rxq_index_mgr_chk #(
    parameter int MAX_DEPTH = 64,
    parameter int ADDR_W    = 16,
    parameter int IDX_W     = 6,
    parameter int CNT_W     = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_overwrite,
    input logic              frame_store,
    input logic              elem_ack,
    input logic              lost_clr,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [IDX_W-1:0]  put_idx,
    input logic [IDX_W-1:0]  get_idx,
    input logic [CNT_W-1:0]  fill_level,
    input logic              full,
    input logic              empty,
    input logic              lost_flag
);
    p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (empty && !full && fill_level == '0 && !lost_flag && put_idx == '0 && get_idx == '0));

    p_put_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(put_idx));

    p_get_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!elem_ack && !(full && frame_store && cfg_overwrite)) |=> $stable(get_idx));

    p_ack_empty_r3: assert property (@(posedge clk) disable iff (rst)
        (empty && !frame_store) |=> (empty && $stable(get_idx)));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (fill_level <= CNT_W'(MAX_DEPTH)) && !(full && empty));

    p_block_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (full && frame_store && !elem_ack && !cfg_overwrite) |-> !wr_en);

    p_block_lost_r6: assert property (@(posedge clk) disable iff (rst)
        (full && frame_store && !elem_ack && !cfg_overwrite) |=> (lost_flag && $stable(put_idx)));

    p_lost_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (lost_flag && !lost_clr) |=> lost_flag);

    p_ovw_oldest_r8: assert property (@(posedge clk) disable iff (rst)
        (full && frame_store && !elem_ack && cfg_overwrite) |-> (wr_en && wr_addr == rd_addr));

    p_ovw_full_r8: assert property (@(posedge clk) disable iff (rst)
        (full && frame_store && !elem_ack && cfg_overwrite) |=> full);

    p_both_level_r9: assert property (@(posedge clk) disable iff (rst)
        (frame_store && elem_ack && !empty) |=> $stable(fill_level));
endmodule

bind rxq_index_mgr rxq_index_mgr_chk #(
    .MAX_DEPTH (MAX_DEPTH),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
) u_chk (.*);

// File: tb/rxq_index_mgr_bench.sv
module rxq_index_mgr_bench;
    localparam int MAX_DEPTH  = 64;
    localparam int ADDR_W     = 16;
    localparam int ELEM_WORDS = 18;
    localparam int IDX_W      = 6;
    localparam int CNT_W      = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CNT_W-1:0]  cfg_depth = CNT_W'(5);
    logic              cfg_overwrite = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic              frame_store = 1'b0;
    logic              elem_ack = 1'b0;
    logic              lost_clr = 1'b0;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [IDX_W-1:0]  put_idx;
    logic [IDX_W-1:0]  get_idx;
    logic [CNT_W-1:0]  fill_level;
    logic              full;
    logic              empty;
    logic              lost_flag;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    int m_depth, m_put, m_get, m_cnt, m_lost, m_ovw, m_base;

    always #5 clk = ~clk;

    rxq_index_mgr #(
        .MAX_DEPTH  (MAX_DEPTH),
        .ADDR_W     (ADDR_W),
        .ELEM_WORDS (ELEM_WORDS)
    ) u_rxq_index_mgr (
        .clk           (clk),
        .rst           (rst),
        .cfg_depth     (cfg_depth),
        .cfg_overwrite (cfg_overwrite),
        .cfg_base      (cfg_base),
        .frame_store   (frame_store),
        .elem_ack      (elem_ack),
        .lost_clr      (lost_clr),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .rd_addr       (rd_addr),
        .put_idx       (put_idx),
        .get_idx       (get_idx),
        .fill_level    (fill_level),
        .full          (full),
        .empty         (empty),
        .lost_flag     (lost_flag)
    );

    function automatic int eff_depth(input int c);
        if (c == 0) return 1;
        if (c > MAX_DEPTH) return MAX_DEPTH;
        return c;
    endfunction

    function automatic int slot_addr(input int idx);
        return (m_base + idx * ELEM_WORDS) & ((1 << ADDR_W) - 1);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic check_state(input string lvl_tag);
        chk("R2", "put_idx", int'(put_idx), m_put);
        chk("R3", "get_idx", int'(get_idx), m_get);
        chk(lvl_tag, "fill_level", int'(fill_level), m_cnt);
        chk("R5", "full", int'(full), int'(m_cnt == m_depth));
        chk("R5", "empty", int'(empty), int'(m_cnt == 0));
        chk("R6/R7", "lost_flag", int'(lost_flag), m_lost);
        chk("R4", "wr_addr", int'(wr_addr), slot_addr(m_put));
        chk("R4", "rd_addr", int'(rd_addr), slot_addr(m_get));
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input bit st, input bit ak, input bit clr);
        bit ack_eff, room, exp_wen, drop, ovw_ev, both;
        frame_store = st;
        elem_ack    = ak;
        lost_clr    = clr;
        #1;
        ack_eff = ak && (m_cnt > 0);
        room    = (m_cnt < m_depth) || ack_eff;
        exp_wen = st && (room || (m_ovw != 0));
        drop    = st && !room && (m_ovw == 0);
        ovw_ev  = st && !room && (m_ovw != 0);
        both    = st && ack_eff;
        chk(drop ? "R6" : (ovw_ev ? "R8" : "R2"), "wr_en", int'(wr_en), int'(exp_wen));
        if (exp_wen) chk(ovw_ev ? "R8" : "R4", "wr_addr at store", int'(wr_addr), slot_addr(m_put));
        @(posedge clk);
        if (exp_wen) m_put = (m_put + 1) % m_depth;
        if (ack_eff || ovw_ev) m_get = (m_get + 1) % m_depth;
        m_cnt = m_cnt + ((st && room) ? 1 : 0) - (ack_eff ? 1 : 0);
        if (drop) m_lost = 1;
        else if (clr) m_lost = 0;
        @(negedge clk);
        frame_store = 1'b0;
        elem_ack    = 1'b0;
        lost_clr    = 1'b0;
        check_state(both ? "R9" : (ovw_ev ? "R8" : "R5"));
    endtask

    task automatic do_reset(input int depth_cfg, input bit ovw, input int base);
        @(negedge clk);
        rst           = 1'b1;
        cfg_depth     = CNT_W'(depth_cfg);
        cfg_overwrite = ovw;
        cfg_base      = ADDR_W'(base);
        frame_store   = 1'b0;
        elem_ack      = 1'b0;
        lost_clr      = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_depth = eff_depth(depth_cfg);
        m_put = 0; m_get = 0; m_cnt = 0; m_lost = 0;
        m_ovw = ovw; m_base = base;
        chk("R1", "empty after reset", int'(empty), 1);
        chk("R1", "full after reset", int'(full), 0);
        chk("R1", "fill after reset", int'(fill_level), 0);
        chk("R1", "lost after reset", int'(lost_flag), 0);
        chk("R1", "put after reset", int'(put_idx), 0);
        chk("R1", "get after reset", int'(get_idx), 0);
    endtask

    task automatic random_run(input int n, input int st_pct, input int ak_pct);
        for (int i = 0; i < n; i++) begin
            step(($urandom % 100) < st_pct, ($urandom % 100) < ak_pct, ($urandom % 100) < 5);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));

        // Blocking mode, depth 5: fill, drop, sticky flag, simultaneous events.
        do_reset(5, 1'b0, 16'h0400);
        step(0, 1, 0);                                // R3: ack on empty ignored
        for (int i = 0; i < 5; i++) step(1, 0, 0);
        chk("R5", "full at depth 5", int'(full), 1);
        step(1, 0, 0);                                // R6: dropped
        chk("R6", "lost after drop", int'(lost_flag), 1);
        step(0, 0, 0);
        chk("R7", "lost holds", int'(lost_flag), 1);
        step(1, 1, 0);                                // R9: full store + ack accepted
        chk("R9", "still full", int'(full), 1);
        step(1, 0, 1);                                // R7: drop wins over clear
        chk("R7", "set beats clear", int'(lost_flag), 1);
        step(0, 0, 1);
        chk("R7", "cleared", int'(lost_flag), 0);
        for (int i = 0; i < 6; i++) step(0, 1, 0);    // drain plus one extra ack
        chk("R3", "empty after extra ack", int'(empty), 1);
        step(1, 1, 0);                                // store on empty, ack ignored
        chk("R3", "ack ignored with store on empty", int'(fill_level), 1);

        // Overwrite mode, depth 5.
        do_reset(5, 1'b1, 16'h0200);
        for (int i = 0; i < 5; i++) step(1, 0, 0);
        for (int i = 0; i < 3; i++) step(1, 0, 0);    // R8
        chk("R8", "fill stays at depth", int'(fill_level), 5);
        chk("R8", "no lost in overwrite", int'(lost_flag), 0);

        // Depth clamps.
        do_reset(0, 1'b0, 16'h0000);
        step(1, 0, 0);
        chk("R10", "depth 0 acts as 1: full", int'(full), 1);
        step(1, 0, 0);
        chk("R10", "depth 0 acts as 1: drop", int'(lost_flag), 1);
        do_reset(100, 1'b1, 16'hFF00);
        for (int i = 0; i < 64; i++) step(1, 0, 0);
        chk("R10", "depth 100 acts as 64: full", int'(full), 1);
        step(1, 0, 0);

        // Random phases over several depths and both policies.
        for (int c = 0; c < 8; c++) begin
            int dsel;
            dsel = (c % 4 == 0) ? 5 : (c % 4 == 1) ? 64 : (c % 4 == 2) ? 1 : 7;
            do_reset(dsel, c[0] ^ c[2], (c % 2 == 0) ? 32'hFF00 : 32'h1234);
            random_run(200, 75, 25);
            random_run(200, 25, 75);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule